// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front-End

This block is the software-facing side of a serial port. A host reaches it through a simple 32-bit read/write bus that is addressed in bytes over a 64-byte window. It holds the line, divisor, control and flow-control settings and passes them to the serial frame engine as plain signals. It also owns both 16-entry character FIFOs. A bus write to the data offset queues a character for transmission. A bus read of the data offset takes the oldest received character.

Four interrupt sources are latched into an identification register: modem status, receive level, transmit level and receive timeout. Any bus write to that register clears them. Each latched source is masked by its enable bit in the control register, and the results are ORed into one registered interrupt line. Error conditions reported by the frame engine build up in a sticky status register. Any write to the status register clears it.

Top module: `sio_csr_front`

## Requirements
- R1: After reset, bus_rdata and irq are 0, tx_avail is 0, the flag register (offset 0x18) reads 0x90 while cts_async and line_busy are low, and the receive level register (offset 0x38) reads 1.
- R2: The line (0x08), control (0x14), flow-control (0x24) and divisor registers read back what was written. baud_div is {byte at 0x0C, byte at 0x10}. line_cfg, ctrl_cfg and rts_cfg follow their registers.
- R3: A write to offset 0x00 pushes wdata[7:0] into the transmit FIFO. tx_data shows the oldest entry and tx_avail shows that the FIFO is not empty. tx_pop removes the oldest entry. A write while 16 entries are held is dropped.
- R4: A read of offset 0x00 returns the oldest received character on the next cycle and removes it. The FIFO keeps arrival order. A read while the FIFO is empty returns 0 and changes nothing.
- R5: Flag bits: 0 synchronized CTS, 3 busy (line_busy or transmit FIFO not empty), 4 receive FIFO empty, 5 transmit FIFO full, 6 receive FIFO full, 7 transmit FIFO empty.
- R6: Status bits 0 framing, 1 parity, 2 break and 3 overrun are set by rx_err[0..3]. Bit 3 is also set by an rx_push while the receive FIFO is full. Any write to offset 0x04 clears the status register.
- R7: The receive source (ID bit 1) is latched while the receive FIFO holds at least the level at 0x38 (a level of 0 acts as 1). It comes back right after a clear while that holds. A level of 1 fires on a single character.
- R8: The transmit source (ID bit 2) is latched while the transmit FIFO holds no more entries than the level at 0x3C.
- R9: The modem-status source (ID bit 0) is latched on each rising and each falling edge of cts_async, after a two-stage synchronizer.
- R10: The timeout source (ID bit 3) is latched by a one-cycle pulse on rx_timeout.
- R11: Any write to offset 0x1C clears the latched sources. A source event in the same cycle as the clear is kept.
- R12: irq is high when any latched source is set and its enable is set. The enables are control bits 3 (modem), 4 (receive), 5 (transmit) and 6 (timeout). Control bit 0 is the port enable and bit 7 is loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| tx_data | output | 8 | Oldest transmit character |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_pop | input | 1 | Frame engine takes tx_data |
| line_busy | input | 1 | Frame engine is shifting |
| rx_data | input | 8 | Received character |
| rx_push | input | 1 | rx_data is valid |
| rx_err | input | 4 | Error pulses: framing, parity, break, overrun |
| rx_timeout | input | 1 | Receive timeout pulse |
| cts_async | input | 1 | Clear-to-send pin, asynchronous |
| line_cfg | output | 8 | Line control setting |
| baud_div | output | 16 | Divisor |
| ctrl_cfg | output | 8 | Control setting |
| rts_cfg | output | 8 | Flow-control setting |
| irq | output | 1 | Interrupt request |

## Verification
The clear of the identification register and a new source event can fall in the same clock edge. If the clear won, a timeout would be lost without any trace. The bench raises the bus write to offset 0x1C and the rx_timeout pulse in the same cycle. It then requires ID bit 3 to read back set and irq to stay high. A clear with no pulse beside it must drop the same bit, so the test separates "set wins" from "clear never works".

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W = 6;
  localparam int NSRC   = 4;

  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_LINE = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DIVH = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIVL = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IID  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_RTS  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_RXLV = 6'h38;
  localparam logic [ADDR_W-1:0] OFS_TXLV = 6'h3C;

  // interrupt source positions, shared by the ID register and the enables
  localparam int SRC_MS = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_TX = 2;
  localparam int SRC_RT = 3;
  // control bit where the enables start (modem .. timeout = 3..6)
  localparam int CB_IE_LO = 3;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic toggled
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign level   = chain[STAGES-1];
  assign toggled = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clear,
  input  logic [N-1:0] enable,
  output logic [N-1:0] latched,
  output logic         irq
);
  logic [N-1:0] nxt;

  // a new event beside a clear is kept
  always_comb begin
    for (int i = 0; i < N; i++) nxt[i] = (latched[i] && !clear) || set[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latched <= '0;
      irq     <= 1'b0;
    end else begin
      latched <= nxt;
      irq     <= |(nxt & enable);
    end
  end
endmodule

// File: rtl/sio_csr_front.sv
module sio_csr_front
  import sio_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [DW-1:0]     tx_data,
  output logic              tx_avail,
  input  logic              tx_pop,
  input  logic              line_busy,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_push,
  input  logic [3:0]        rx_err,
  input  logic              rx_timeout,
  input  logic              cts_async,
  output logic [7:0]        line_cfg,
  output logic [15:0]       baud_div,
  output logic [7:0]        ctrl_cfg,
  output logic [7:0]        rts_cfg,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       line_q, ctrl_q, rts_q, divh_q, divl_q;
  logic [3:0]       stat_q;
  logic [CNT_W-1:0] rxlv_q, txlv_q, rx_eff_lv;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic [DW-1:0]    rx_head;
  logic             cts_sync, cts_edge;
  logic [NSRC-1:0]  src_set, iid_q;
  logic [31:0]      rd_val;

  wire wr_hit_data = bus_wr && (bus_addr == OFS_DATA);
  wire rd_hit_data = bus_rd && (bus_addr == OFS_DATA);
  wire wr_hit_stat = bus_wr && (bus_addr == OFS_STAT);
  wire wr_hit_iid  = bus_wr && (bus_addr == OFS_IID);

  sio_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_hit_data), .din(bus_wdata[DW-1:0]),
    .pop(tx_pop), .dout(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  sio_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_data),
    .pop(rd_hit_data), .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  sio_edge_sync #(.STAGES(2)) u_cts (
    .clk(clk), .rst(rst), .async_in(cts_async), .level(cts_sync), .toggled(cts_edge)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      ctrl_q <= '0;
      rts_q  <= '0;
      divh_q <= '0;
      divl_q <= '0;
      rxlv_q <= CNT_W'(1);
      txlv_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_LINE: line_q <= bus_wdata[7:0];
        OFS_CTRL: ctrl_q <= bus_wdata[7:0];
        OFS_RTS:  rts_q  <= bus_wdata[7:0];
        OFS_DIVH: divh_q <= bus_wdata[7:0];
        OFS_DIVL: divl_q <= bus_wdata[7:0];
        OFS_RXLV: rxlv_q <= bus_wdata[CNT_W-1:0];
        OFS_TXLV: txlv_q <= bus_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  // sticky error status, events beside a clear are kept
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (wr_hit_stat ? 4'b0 : stat_q)
                     | {rx_err[3] | (rx_push & rx_full), rx_err[2:0]};
  end

  // interrupt sources
  assign rx_eff_lv = (rxlv_q == '0) ? CNT_W'(1) : rxlv_q;
  always_comb begin
    src_set         = '0;
    src_set[SRC_MS] = cts_edge;
    src_set[SRC_RX] = (rx_count >= rx_eff_lv);
    src_set[SRC_TX] = (tx_count <= txlv_q);
    src_set[SRC_RT] = rx_timeout;
  end

  sio_irq_ctl #(.N(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set(src_set), .clear(wr_hit_iid),
    .enable(ctrl_q[CB_IE_LO +: NSRC]), .latched(iid_q), .irq(irq)
  );

  // read mux
  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_DATA: rd_val[DW-1:0] = rx_empty ? '0 : rx_head;
      OFS_STAT: rd_val[3:0]    = stat_q;
      OFS_LINE: rd_val[7:0]    = line_q;
      OFS_DIVH: rd_val[7:0]    = divh_q;
      OFS_DIVL: rd_val[7:0]    = divl_q;
      OFS_CTRL: rd_val[7:0]    = ctrl_q;
      OFS_FLAG: rd_val[7:0]    = {tx_empty, rx_full, tx_full, rx_empty,
                                  line_busy | !tx_empty, 2'b00, cts_sync};
      OFS_IID:  rd_val[NSRC-1:0] = iid_q;
      OFS_RTS:  rd_val[7:0]    = rts_q;
      OFS_RXLV: rd_val[CNT_W-1:0] = rxlv_q;
      OFS_TXLV: rd_val[CNT_W-1:0] = txlv_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign tx_avail = !tx_empty;
  assign line_cfg = line_q;
  assign ctrl_cfg = ctrl_q;
  assign rts_cfg  = rts_q;
  assign baud_div = {divh_q, divl_q};
endmodule

// File: rtl/sio_csr_front_chk.sv
module sio_csr_front_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic [5:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic [3:0]       rx_err,
  input logic [3:0]       stat_q,
  input logic             rx_timeout,
  input logic             cts_edge,
  input logic [3:0]       iid_q,
  input logic [7:0]       ctrl_q,
  input logic             irq
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    tx_count <= CNT_W'(DEPTH));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 6'h00 && rx_count == '0) |=> (bus_rdata == 32'h0));

  // R4
  rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CNT_W'(DEPTH));

  // R6
  parity_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rx_err[1] |=> stat_q[1]);

  // R9
  modem_latch_chk: assert property (@(posedge clk) disable iff (rst)
    cts_edge |=> iid_q[0]);

  // R10
  timeout_latch_chk: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |=> iid_q[3]);

  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[6:3] == 4'b0 && $past(ctrl_q[6:3]) == 4'b0) |-> !irq);
endmodule

bind sio_csr_front sio_csr_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .rx_count(rx_count), .tx_count(tx_count), .rx_err(rx_err), .stat_q(stat_q),
  .rx_timeout(rx_timeout), .cts_edge(cts_edge), .iid_q(iid_q), .ctrl_q(ctrl_q), .irq(irq)
);

// File: tb/tb_sio_csr_front.sv
module tb_sio_csr_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_avail;
  logic        tx_pop = 0, line_busy = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_push = 0;
  logic [3:0]  rx_err = '0;
  logic        rx_timeout = 0, cts_async = 0;
  logic [7:0]  line_cfg, ctrl_cfg, rts_cfg;
  logic [15:0] baud_div;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_csr_front dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_avail(tx_avail),
    .tx_pop(tx_pop), .line_busy(line_busy), .rx_data(rx_data), .rx_push(rx_push),
    .rx_err(rx_err), .rx_timeout(rx_timeout), .cts_async(cts_async),
    .line_cfg(line_cfg), .baud_div(baud_div), .ctrl_cfg(ctrl_cfg), .rts_cfg(rts_cfg),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_data = d;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_avail", {31'b0, tx_avail}, 0);
    rd(6'h18, v); chk("R1 flags", v, 32'h90);
    rd(6'h38, v); chk("R1 rx level", v, 1);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(6'h14, 32'h81); wr(6'h0C, 32'h12); wr(6'h10, 32'h34);
    wr(6'h08, 32'h6A); wr(6'h24, 32'h25);
    chk("R2 ctrl_cfg", {24'b0, ctrl_cfg}, 32'h81);
    chk("R2 baud_div", {16'b0, baud_div}, 32'h1234);
    chk("R2 line_cfg", {24'b0, line_cfg}, 32'h6A);
    chk("R2 rts_cfg", {24'b0, rts_cfg}, 32'h25);
    rd(6'h08, v); chk("R2 line readback", v, 32'h6A);
    rd(6'h0C, v); chk("R2 div high readback", v, 32'h12);
    rd(6'h24, v); chk("R2 rts readback", v, 32'h25);
    wr(6'h14, 32'h01);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    wr(6'h00, 32'hA5);
    chk("R3 tx_avail", {31'b0, tx_avail}, 1);
    chk("R3 tx_data", {24'b0, tx_data}, 32'hA5);
    rd(6'h18, v); chk("R5 flags busy", v, 32'h18);
    for (int i = 1; i < 16; i++) wr(6'h00, 32'h40 + i);
    rd(6'h18, v); chk("R5 flags tx full", v, 32'h38);
    wr(6'h00, 32'hEE);
    chk("R3 head after full", {24'b0, tx_data}, 32'hA5);
    for (int i = 0; i < 15; i++) pop_tx();
    chk("R3 last kept entry", {24'b0, tx_data}, 32'h4F);
    pop_tx();
    chk("R3 drained, dropped write absent", {31'b0, tx_avail}, 0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    rd(6'h00, v); chk("R4 empty read", v, 0);
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    rd(6'h00, v); chk("R4 first", v, 32'h11);
    rd(6'h00, v); chk("R4 second", v, 32'h22);
    rd(6'h00, v); chk("R4 third", v, 32'h33);
    rd(6'h00, v); chk("R4 empty again", v, 0);
    rd(6'h18, v); chk("R4 empty unchanged flags", v, 32'h90);
  endtask

  task automatic t_status();
    logic [31:0] v;
    @(negedge clk); rx_err = 4'b0011;
    @(negedge clk); rx_err = 4'b0000;
    rd(6'h04, v); chk("R6 fe+pe", v, 32'h3);
    for (int i = 0; i < 17; i++) push_rx(8'h60 + 8'(i));
    rd(6'h04, v); chk("R6 overrun", v, 32'hB);
    rd(6'h18, v); chk("R5 flags rx full", v, 32'hC0);
    wr(6'h04, 32'h0);
    rd(6'h04, v); chk("R6 cleared", v, 0);
    rd(6'h00, v); chk("R4 oldest after overrun", v, 32'h60);
    for (int i = 0; i < 15; i++) rd(6'h00, v);
    chk("R4 last stored", v, 32'h6F);
    rd(6'h18, v); chk("R5 flags drained", v, 32'h90);
  endtask

  task automatic t_rx_irq();
    logic [31:0] v;
    wr(6'h14, 32'h11); wr(6'h1C, 0);
    chk("R7 idle no irq", {31'b0, irq}, 0);
    push_rx(8'h01); idle(2);
    chk("R7 level 1 fires", {31'b0, irq}, 1);
    wr(6'h1C, 0);
    chk("R7 held after clear", {31'b0, irq}, 1);
    rd(6'h00, v); wr(6'h1C, 0);
    chk("R7 clear after drain", {31'b0, irq}, 0);
    wr(6'h38, 3); rd(6'h38, v); chk("R7 level readback", v, 3);
    push_rx(8'h02); push_rx(8'h03); idle(2);
    chk("R7 below level", {31'b0, irq}, 0);
    push_rx(8'h04); idle(2);
    chk("R7 at level", {31'b0, irq}, 1);
    for (int i = 0; i < 3; i++) rd(6'h00, v);
    wr(6'h1C, 0); wr(6'h38, 1);
    chk("R7 cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_tx_irq();
    wr(6'h14, 32'h21); idle(2);
    chk("R8 empty at level 0", {31'b0, irq}, 1);
    wr(6'h00, 1); wr(6'h00, 2); wr(6'h1C, 0);
    chk("R8 two above level", {31'b0, irq}, 0);
    wr(6'h3C, 2); idle(2);
    chk("R8 at level 2", {31'b0, irq}, 1);
    pop_tx(); pop_tx();
  endtask

  task automatic t_cts();
    logic [31:0] v;
    wr(6'h14, 32'h09); wr(6'h1C, 0);
    chk("R9 quiet", {31'b0, irq}, 0);
    @(negedge clk); cts_async = 1; idle(4);
    chk("R9 rising edge", {31'b0, irq}, 1);
    rd(6'h18, v); chk("R5 cts flag", v, 32'h91);
    wr(6'h1C, 0);
    chk("R9 cleared", {31'b0, irq}, 0);
    @(negedge clk); cts_async = 0; idle(4);
    chk("R9 falling edge", {31'b0, irq}, 1);
  endtask

  task automatic t_timeout_race();
    logic [31:0] v;
    wr(6'h14, 32'h41); wr(6'h1C, 0);
    @(negedge clk); rx_timeout = 1;
    @(negedge clk); rx_timeout = 0;
    rd(6'h1C, v); chk("R10 timeout latched", v & 32'h8, 32'h8);
    chk("R10 irq", {31'b0, irq}, 1);
    wr(6'h1C, 0);
    rd(6'h1C, v); chk("R11 plain clear", v & 32'h8, 0);
    chk("R11 irq low", {31'b0, irq}, 0);
    @(negedge clk); bus_wr = 1; bus_addr = 6'h1C; bus_wdata = 0; rx_timeout = 1;
    @(negedge clk); bus_wr = 0; rx_timeout = 0;
    rd(6'h1C, v); chk("R11 event beside clear kept", v & 32'h8, 32'h8);
    chk("R11 irq kept", {31'b0, irq}, 1);
  endtask

  task automatic t_mask();
    wr(6'h1C, 0); wr(6'h14, 32'h01); idle(2);
    chk("R12 masked", {31'b0, irq}, 0);
    wr(6'h14, 32'h21); idle(1);
    chk("R12 unmasked tx", {31'b0, irq}, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_tx();
    t_rx();
    t_status();
    t_rx_irq();
    t_tx_irq();
    t_cts();
    t_timeout_race();
    t_mask();
    finish_run();
  end
endmodule